// File: doc/BRIEF.md
# Multiplexed Address/Data Burst Write Sink

This block sits on the peripheral side of a synchronous bus where address and data share one 16-bit path. The chip-select, address-valid and write-enable strobes are active low. On each rising clock edge it samples the strobes and the shared path. When address-valid is active, it takes a word address from the low bits of the path. Each later clock with write-enable active is a data beat. The block stores each beat's word in an internal memory, at the latched address plus the beat index. Addresses wrap within the memory. A registered readback port gives access to the stored words.

Some masters keep the strobes active for one clock too many at the end of a burst and send the last word a second time. To cope with this, the block holds a programmable expected burst length. After it has captured that many beats in one chip-select window, it discards every further beat. Each discarded beat sets a sticky flag and advances a saturating counter. Because of this, an overlong burst never writes beyond its intended last address.

Top module: `adm_burst_sink`

## Requirements
- R1: After reset the discard flag is 0, the discard counter is 0 and the expected burst length is 16.
- R2: A clock with chip-select and address-valid both low latches AD[7:0] as the base word address, clears the beat index and writes nothing.
- R3: The k-th data beat (counting from 0) writes its AD word to address base+k. A data beat is a clock after the address clock with chip-select and write-enable low and address-valid high.
- R4: A single write, one address clock followed by one data clock, stores exactly one word at the base address.
- R5: Bursts of 4, 8 and 16 words store every word at consecutive addresses when the expected length matches.
- R6: A data beat that arrives after the expected number of beats has been captured in the same window leaves the memory unchanged, including the address just past the burst.
- R7: Each discarded beat sets the sticky discard flag and raises the discard counter by one. The counter saturates at its maximum.
- R8: Chip-select high returns the block to idle and clears the beat index, so the next burst captures in full from its own base address.
- R9: Word addresses wrap modulo 256.
- R10: With cfg_len_we high at a clock edge, the expected length loads from cfg_len, clamped to 16. The new length governs all later beats.
- R11: A clock in the data phase with write-enable high neither stores a word nor advances the beat index.
- R12: rb_data shows the word at rb_addr one clock after rb_addr is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_cs_n | input | 1 | Chip-select, active low |
| bus_adv_n | input | 1 | Address-valid, active low |
| bus_we_n | input | 1 | Write-enable, active low |
| bus_ad | input | 16 | Shared address/data path |
| cfg_len | input | 5 | Expected burst length value to load |
| cfg_len_we | input | 1 | Load strobe for cfg_len |
| rb_addr | input | 8 | Readback word address |
| rb_data | output | 16 | Readback word, one clock latency |
| drop_seen | output | 1 | Sticky flag: a beat was discarded |
| drop_count | output | 8 | Saturating count of discarded beats |

## Verification
The bound checker checks the following on every cycle. A store only happens when the strobes mark a data beat. A beat is never both stored and discarded. Chip-select high blocks both actions. The flag never falls once set. Each discard advances the counter by exactly one. The number of stores per window never exceeds the maximum length. Only the bench's scenarios can show that the right word lands at the right address, that the word past an overlong burst survives, that wrap-around works, that clamping and reloading the length behave as required, and that an idle write-enable clock does not shift later beats.

// File: rtl/adm_sink_pkg.sv
`timescale 1ns/1ps
package adm_sink_pkg;
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_DATA = 1'b1
    } phase_e;
endpackage

// File: rtl/adm_sink_ctrl.sv
`timescale 1ns/1ps
// Bus decode: address latch, beat indexing, length limit and discard decision.
module adm_sink_ctrl
    import adm_sink_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 16,
    parameter int MAX_BURST = 16,
    parameter int LEN_W     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              adv_n,
    input  logic              we_n,
    input  logic [DATA_W-1:0] ad,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic              cfg_len_we,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              drop_pulse
);
    typedef struct packed {
        phase_e             phase;
        logic [ADDR_W-1:0]  base;
        logic [LEN_W-1:0]   beats;
        logic [LEN_W-1:0]   len;
    } ctrl_t;

    localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(MAX_BURST);

    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d     = ctrl_q;
        wr_en      = 1'b0;
        drop_pulse = 1'b0;
        wr_addr    = ctrl_q.base + ADDR_W'(ctrl_q.beats);
        wr_data    = ad;

        if (cfg_len_we) begin
            ctrl_d.len = (cfg_len > LEN_MAX) ? LEN_MAX : cfg_len;
        end

        if (cs_n) begin
            ctrl_d.phase = PH_IDLE;
            ctrl_d.beats = '0;
        end else if (!adv_n) begin
            ctrl_d.phase = PH_DATA;
            ctrl_d.base  = ad[ADDR_W-1:0];
            ctrl_d.beats = '0;
        end else if (ctrl_q.phase == PH_DATA && !we_n) begin
            if (ctrl_q.beats < ctrl_q.len) begin
                wr_en        = 1'b1;
                ctrl_d.beats = ctrl_q.beats + LEN_W'(1);
            end else begin
                drop_pulse   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q.phase <= PH_IDLE;
            ctrl_q.base  <= '0;
            ctrl_q.beats <= '0;
            ctrl_q.len   <= LEN_MAX;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end
endmodule

// File: rtl/adm_sink_ram.sv
`timescale 1ns/1ps
// Word store: one write port, one registered read port.
module adm_sink_ram #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
        rdata_q <= mem_q[raddr];
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/adm_sink_drop_stat.sv
`timescale 1ns/1ps
// Sticky discard flag and saturating discard counter.
module adm_sink_drop_stat #(
    parameter int DROP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              drop_pulse,
    output logic              drop_seen,
    output logic [DROP_W-1:0] drop_count
);
    typedef struct packed {
        logic              seen;
        logic [DROP_W-1:0] cnt;
    } stat_t;

    stat_t stat_d, stat_q;

    always_comb begin
        stat_d = stat_q;
        if (drop_pulse) begin
            stat_d.seen = 1'b1;
            if (stat_q.cnt != {DROP_W{1'b1}}) begin
                stat_d.cnt = stat_q.cnt + DROP_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= stat_d;
        end
    end

    assign drop_seen  = stat_q.seen;
    assign drop_count = stat_q.cnt;
endmodule

// File: rtl/adm_burst_sink.sv
`timescale 1ns/1ps
// Top: burst write sink for a synchronous multiplexed address/data bus.
module adm_burst_sink #(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 16,
    parameter int MAX_BURST = 16,
    parameter int DROP_W    = 8,
    parameter int LEN_W     = $clog2(MAX_BURST + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_cs_n,
    input  logic              bus_adv_n,
    input  logic              bus_we_n,
    input  logic [DATA_W-1:0] bus_ad,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic              cfg_len_we,
    input  logic [ADDR_W-1:0] rb_addr,
    output logic [DATA_W-1:0] rb_data,
    output logic              drop_seen,
    output logic [DROP_W-1:0] drop_count
);
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic              drop_pulse;

    adm_sink_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_BURST(MAX_BURST), .LEN_W(LEN_W)
    ) ctrl_i (
        .clk(clk), .rst_n(rst_n),
        .cs_n(bus_cs_n), .adv_n(bus_adv_n), .we_n(bus_we_n), .ad(bus_ad),
        .cfg_len(cfg_len), .cfg_len_we(cfg_len_we),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .drop_pulse(drop_pulse)
    );

    adm_sink_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) ram_i (
        .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
        .raddr(rb_addr), .rdata(rb_data)
    );

    adm_sink_drop_stat #(.DROP_W(DROP_W)) stat_i (
        .clk(clk), .rst_n(rst_n), .drop_pulse(drop_pulse),
        .drop_seen(drop_seen), .drop_count(drop_count)
    );
endmodule

// File: rtl/adm_burst_sink_chk.sv
`timescale 1ns/1ps
module adm_burst_sink_chk #(
    parameter int MAX_BURST = 16,
    parameter int DROP_W    = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              adv_n,
    input logic              we_n,
    input logic              wr_en,
    input logic              drop_pulse,
    input logic              drop_seen,
    input logic [DROP_W-1:0] drop_count
);
    localparam int CW = $clog2(MAX_BURST + 2);

    logic [CW-1:0] win_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || cs_n || !adv_n) begin
            win_cnt <= '0;
        end else if (wr_en) begin
            win_cnt <= win_cnt + CW'(1);
        end
    end

    // R3
    wr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (!cs_n && !we_n && adv_n));

    // R6
    wr_drop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_en, drop_pulse}));

    // R6
    burst_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_cnt <= CW'(MAX_BURST));

    // R7
    sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drop_seen |=> drop_seen);

    // R7
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_pulse && drop_count != {DROP_W{1'b1}}) |=>
            (drop_count == $past(drop_count) + DROP_W'(1)));

    // R8
    cs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (!wr_en && !drop_pulse));
endmodule

bind adm_burst_sink adm_burst_sink_chk #(
    .MAX_BURST(MAX_BURST), .DROP_W(DROP_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .cs_n(bus_cs_n), .adv_n(bus_adv_n), .we_n(bus_we_n),
    .wr_en(wr_en), .drop_pulse(drop_pulse),
    .drop_seen(drop_seen), .drop_count(drop_count)
);

// File: tb/adm_burst_sink_tb_top.sv
`timescale 1ns/1ps
module adm_burst_sink_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_cs_n = 1'b1, bus_adv_n = 1'b1, bus_we_n = 1'b1;
    logic [15:0] bus_ad = '0;
    logic [4:0]  cfg_len = '0;
    logic        cfg_len_we = 1'b0;
    logic [7:0]  rb_addr = '0;
    logic [15:0] rb_data;
    logic        drop_seen;
    logic [7:0]  drop_count;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // bench-side model built from the requirements
    logic [15:0] model [256];
    bit          known [256];
    int          len_m = 16;
    int          drops_m = 0;

    logic [23:0] exp_q [$];
    string       tag_q [$];

    always #10 clk = ~clk;

    adm_burst_sink dut_i (
        .clk(clk), .rst_n(rst_n), .bus_cs_n(bus_cs_n), .bus_adv_n(bus_adv_n),
        .bus_we_n(bus_we_n), .bus_ad(bus_ad), .cfg_len(cfg_len),
        .cfg_len_we(cfg_len_we), .rb_addr(rb_addr), .rb_data(rb_data),
        .drop_seen(drop_seen), .drop_count(drop_count)
    );

    task automatic check_val(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic push_exp(input logic [7:0] a, input string tag);
        if (known[a]) begin
            exp_q.push_back({a, model[a]});
            tag_q.push_back(tag);
        end
    endtask

    // driver: one address clock, data beats, optional repeated last beat
    task automatic do_burst(input logic [7:0] base, input int n, input bit dup,
                            input logic [15:0] seed, input string tag);
        automatic int total = n + (dup ? 1 : 0);
        @(negedge clk);
        bus_cs_n = 1'b0; bus_adv_n = 1'b0; bus_we_n = 1'b0; bus_ad = {8'h00, base};
        for (int i = 0; i < total; i++) begin
            automatic int idx = (i < n) ? i : n - 1;
            automatic logic [15:0] w = seed + 16'(idx) * 16'h0111;
            @(negedge clk);
            bus_adv_n = 1'b1; bus_ad = w;
            if (i < len_m) begin
                model[base + 8'(i)] = w;
                known[base + 8'(i)] = 1'b1;
            end else begin
                drops_m++;
            end
        end
        @(negedge clk);
        bus_cs_n = 1'b1; bus_we_n = 1'b1; bus_adv_n = 1'b1; bus_ad = '0;
        for (int k = 0; k <= total; k++) push_exp(base + 8'(k), tag);
    endtask

    task automatic set_len(input int v);
        @(negedge clk);
        cfg_len = 5'(v); cfg_len_we = 1'b1;
        @(negedge clk);
        cfg_len_we = 1'b0;
        len_m = (v > 16) ? 16 : v;
    endtask

    // monitor: pops expected items and compares against the readback port
    task automatic drain();
        while (exp_q.size() > 0) begin
            automatic logic [23:0] it = exp_q.pop_front();
            automatic string tg = tag_q.pop_front();
            @(negedge clk);
            rb_addr = it[23:16];
            @(posedge clk);
            @(negedge clk);
            check_val($sformatf("%s R12 addr %0h", tg, it[23:16]), rb_data, it[15:0]);
        end
    endtask

    task automatic check_drops(input string tag);
        @(negedge clk);
        check_val({tag, " R7 count"}, drop_count, drops_m);
        check_val({tag, " R7 flag"}, drop_seen, (drops_m > 0) ? 1 : 0);
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=complete");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) known[i] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_val("R1 flag", drop_seen, 0);
        check_val("R1 count", drop_count, 0);

        // R4 R2: single writes also prefill guard words
        do_burst(8'h24, 1, 1'b0, 16'hA5A5, "R4");
        do_burst(8'h48, 1, 1'b0, 16'h5A5A, "R4");
        do_burst(8'h08, 1, 1'b0, 16'h0F0F, "R2");
        do_burst(8'h61, 1, 1'b0, 16'h7777, "R4");
        do_burst(8'hB0, 1, 1'b0, 16'h3C3C, "R4");
        drain();
        check_drops("R4");

        // R1 default length 16, R9 wrap, R6 guard at 0x08
        do_burst(8'hF8, 16, 1'b1, 16'h1000, "R9");
        drain();
        check_drops("R1");

        // R10 R5 R6: length 4 and 8 with repeated last beat
        set_len(4);
        do_burst(8'h20, 4, 1'b1, 16'h2000, "R5");
        drain();
        check_drops("R6");
        set_len(8);
        do_burst(8'h40, 8, 1'b1, 16'h4000, "R5");
        drain();
        check_drops("R6");

        // R8 back-to-back windows
        do_burst(8'h80, 8, 1'b0, 16'h8000, "R8");
        do_burst(8'h90, 8, 1'b1, 16'h9000, "R8");
        drain();
        check_drops("R8");

        // R11: idle write-enable clock inside data phase
        @(negedge clk);
        bus_cs_n = 1'b0; bus_adv_n = 1'b0; bus_we_n = 1'b0; bus_ad = 16'h0060;
        @(negedge clk);
        bus_adv_n = 1'b1; bus_we_n = 1'b1; bus_ad = 16'hDEAD;
        @(negedge clk);
        bus_we_n = 1'b0; bus_ad = 16'h1234;
        @(negedge clk);
        bus_cs_n = 1'b1; bus_we_n = 1'b1; bus_ad = '0;
        model[8'h60] = 16'h1234; known[8'h60] = 1'b1;
        push_exp(8'h60, "R11"); push_exp(8'h61, "R11");
        drain();
        check_drops("R11");

        // R10 clamp: 31 loads as 16; R5 full 16-word burst
        set_len(31);
        do_burst(8'hA0, 16, 1'b1, 16'hA000, "R10");
        drain();
        check_drops("R10");

        // short burst below the limit: no discard
        do_burst(8'hC0, 2, 1'b0, 16'hC000, "R3");
        drain();
        check_drops("R3");

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule